// File: doc/BRIEF.md
# Clocked Serial Transmitter with Trailing Marker

This block shifts a data word out on a serial data pin, paced by a serial clock that it generates itself. The word is 8 or 16 bits long. The lowest bit goes out first. In 16-bit mode the low byte is sent before the high byte. The data pin is open-drain: the block only ever pulls the line low, and an external pull-up supplies the high level.

Once the last data bit has been sent, the transfer-complete interrupt flag is set. If the tail feature is enabled, the block then appends a short marker waveform before it returns to idle. The marker takes one of two forms:

- **Hold style:** the clock stays high and the line is released for two serial clock periods.
- **Latch style:** the clock stays high, the line is pulled low for one period and then released for one period.

Software sets up the configuration and pulses a start strobe. The data bytes are captured when the start strobe is accepted.

Top module: `sync_tx_tail`

## Requirements
- R1: After reset, and whenever no transfer or marker is in progress, `sck` is 1, `so_oe` is 0, `busy` is 0 and `tail_active` is 0. The interrupt flag `irq` is 0 after reset.
- R2: In 8-bit mode (`cfg_wide`=0) the block sends only `data_lo`, bit 0 first and bit 7 last. `so_oe`=1 while the current bit is 0, and `so_oe`=0 while it is 1.
- R3: In 16-bit mode (`cfg_wide`=1) the block sends `data_lo` bits 0..7 and then `data_hi` bits 0..7, which is 16 bits in total.
- R4: With `cfg_div_sel`=n, every serial clock half-period lasts 2^n system clocks, so one period t is 2^(n+1) clocks. Each bit starts with `sck` low for a half-period and ends with `sck` high for a half-period. The data line changes only when `sck` falls.
- R5: `busy` rises in the cycle after `start` is accepted and falls at the end of the last bit's high half-period. In that same cycle `irq` is set. `irq` then stays set until `irq_clr` is asserted.
- R6: With the tail enabled and `cfg_tail_latch`=0 (hold style), the block holds `sck` high and keeps `so_oe` at 0 for 2t after the data ends. `tail_active` is 1 for that whole interval and then the block goes idle.
- R7: With the tail enabled and `cfg_tail_latch`=1 (latch style), `sck` stays high, `so_oe` is 1 for t and then 0 for t, and `tail_active` is 1 across both intervals.
- R8: With `cfg_tail_en`=0, the block goes idle directly after the last data bit, and `tail_active` never rises.
- R9: A `start` pulse is ignored while `busy` or `tail_active` is 1. The waveform already in progress is not changed.
- R10: A configuration write (`cfg_we`) is accepted only while idle. A write made during a transfer or marker has no effect on that transfer or on the next one.
- R11: `irq_clr` clears `irq` on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe, accepted only when idle |
| cfg_wide | input | 1 | Word length: 0 selects 8 bits, 1 selects 16 bits |
| cfg_tail_en | input | 1 | Enables the trailing marker |
| cfg_tail_latch | input | 1 | Marker style: 0 selects hold, 1 selects latch |
| cfg_div_sel | input | PSW | Clock prescaler select n; the half-period is 2^n clocks |
| data_lo | input | 8 | Low data byte, captured when start is accepted |
| data_hi | input | 8 | High data byte, used only in 16-bit mode |
| start | input | 1 | Start strobe |
| irq_clr | input | 1 | Clears the interrupt flag |
| sck | output | 1 | Serial clock; idles high |
| so_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| busy | output | 1 | A data transfer is in progress |
| tail_active | output | 1 | The trailing marker is being output |
| irq | output | 1 | Transfer-complete interrupt flag |

## Verification
The hardest situations to reach from the ports are the attempts to disturb a transfer that is already running:

- a second start strobe during the data phase;
- a second start strobe during the latch-style marker;
- a configuration write, with every field inverted, made mid-transfer.

To reach them, one vector in the table carries a flag. When the flag is set, the bench issues these pokes at fixed cycle offsets while it compares the waveform cycle by cycle against its own model. A directed transfer that follows, with no fresh configuration write, shows that the inverted write was dropped.

// File: rtl/sync_tx_tail.sv
`timescale 1ns/1ps
module sync_tx_tail #(
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic           cfg_wide,
  input  logic           cfg_tail_en,
  input  logic           cfg_tail_latch,
  input  logic [PSW-1:0] cfg_div_sel,
  input  logic [7:0]     data_lo,
  input  logic [7:0]     data_hi,
  input  logic           start,
  input  logic           irq_clr,
  output logic           sck,
  output logic           so_oe,
  output logic           busy,
  output logic           tail_active,
  output logic           irq
);
  localparam int DCW = (1 << PSW) - 1;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_TAIL} st_t;

  st_t            st;
  logic [DCW-1:0] dcnt;
  logic [4:0]     ph;
  logic [15:0]    sh;
  logic           sck_q, oe_q, irq_q;
  logic           wide_q, tail_en_q, latch_q;
  logic [PSW-1:0] sel_q;

  logic [DCW-1:0] lim;
  logic           half_end;
  logic [4:0]     last_ph;

  assign lim      = ({{(DCW-1){1'b0}}, 1'b1} << sel_q) - 1'b1;
  assign half_end = (dcnt == lim);
  assign last_ph  = wide_q ? 5'd31 : 5'd15;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      dcnt      <= '0;
      ph        <= '0;
      sh        <= '0;
      sck_q     <= 1'b1;
      oe_q      <= 1'b0;
      irq_q     <= 1'b0;
      wide_q    <= 1'b0;
      tail_en_q <= 1'b0;
      latch_q   <= 1'b0;
      sel_q     <= '0;
    end else begin
      if (irq_clr) irq_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cfg_we) begin
            wide_q    <= cfg_wide;
            tail_en_q <= cfg_tail_en;
            latch_q   <= cfg_tail_latch;
            sel_q     <= cfg_div_sel;
          end
          if (start) begin
            st    <= S_DATA;
            sh    <= {data_hi, data_lo};
            ph    <= '0;
            dcnt  <= '0;
            sck_q <= 1'b0;
            oe_q  <= ~data_lo[0];
          end
        end
        S_DATA: begin
          if (half_end) begin
            dcnt <= '0;
            ph   <= ph + 5'd1;
            if (!ph[0]) begin
              sck_q <= 1'b1;
            end else if (ph == last_ph) begin
              irq_q <= 1'b1;
              ph    <= '0;
              if (tail_en_q) begin
                st   <= S_TAIL;
                oe_q <= latch_q;
              end else begin
                st   <= S_IDLE;
                oe_q <= 1'b0;
              end
            end else begin
              sck_q <= 1'b0;
              sh    <= sh >> 1;
              oe_q  <= ~sh[1];
            end
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        S_TAIL: begin
          if (half_end) begin
            dcnt <= '0;
            ph   <= ph + 5'd1;
            if (ph == 5'd1) oe_q <= 1'b0;
            if (ph == 5'd3) st <= S_IDLE;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sck         = sck_q;
  assign so_oe       = oe_q;
  assign busy        = (st == S_DATA);
  assign tail_active = (st == S_TAIL);
  assign irq         = irq_q;
endmodule

module sync_tx_tail_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic so_oe,
  input logic busy,
  input logic tail_active,
  input logic irq
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tail_active) |-> (sck && !so_oe));

  a_r4_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(sck)) |-> $stable(so_oe));

  a_r5_irq_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  a_r6_tail_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    tail_active |-> sck);

  a_r9_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && tail_active));
endmodule

bind sync_tx_tail sync_tx_tail_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .so_oe(so_oe),
  .busy(busy), .tail_active(tail_active), .irq(irq)
);

// File: tb/sim_sync_tx_tail.sv
`timescale 1ns/1ps
module sim_sync_tx_tail;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_wide = 1'b0, cfg_tail_en = 1'b0, cfg_tail_latch = 1'b0;
  logic [2:0] cfg_div_sel = 3'd0;
  logic [7:0] data_lo = 8'h00, data_hi = 8'h00;
  logic start = 1'b0, irq_clr = 1'b0;
  logic sck, so_oe, busy, tail_active, irq;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_tx_tail #(.PSW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wide(cfg_wide),
    .cfg_tail_en(cfg_tail_en), .cfg_tail_latch(cfg_tail_latch),
    .cfg_div_sel(cfg_div_sel), .data_lo(data_lo), .data_hi(data_hi),
    .start(start), .irq_clr(irq_clr), .sck(sck), .so_oe(so_oe),
    .busy(busy), .tail_active(tail_active), .irq(irq)
  );

  // {wide, tail_en, latch, sel[2:0], hi[7:0], lo[7:0], poke}
  localparam logic [22:0] VT [6] = '{
    {1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 8'hA5, 1'b0},
    {1'b1, 1'b0, 1'b0, 3'd1, 8'h3C, 8'h81, 1'b0},
    {1'b0, 1'b1, 1'b0, 3'd2, 8'hFF, 8'h5A, 1'b0},
    {1'b1, 1'b1, 1'b1, 3'd0, 8'hC3, 8'h0F, 1'b0},
    {1'b1, 1'b1, 1'b0, 3'd7, 8'h55, 8'hAA, 1'b0},
    {1'b0, 1'b1, 1'b1, 3'd3, 8'h00, 8'h96, 1'b1}
  };

  task automatic chk(input logic act, input logic exp, input string tag, input int c);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, c, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic t, input logic l, input logic [2:0] s,
                      input logic [7:0] hi, input logic [7:0] lo, input bit do_cfg, input bit poke);
    int h, n, total, j;
    logic [15:0] word;
    logic esck, eoe, ebusy, etail, eirq;
    string dtag;
    h = 1 << s;
    n = w ? 16 : 8;
    total = 2 * n * h + (t ? 4 * h : 0) + 3;
    word = w ? {hi, lo} : {8'h00, lo};
    dtag = w ? "R3" : "R2";
    if (do_cfg) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_wide = w; cfg_tail_en = t; cfg_tail_latch = l; cfg_div_sel = s;
      @(negedge clk);
      cfg_we = 1'b0;
    end
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq, 1'b0, "R11 irq cleared", 0);
    data_hi = hi; data_lo = lo; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    data_hi = ~hi; data_lo = ~lo;
    for (int c = 0; c < total; c++) begin
      j = c / h;
      if (j < 2 * n) begin
        esck = j[0]; eoe = ~word[j/2]; ebusy = 1'b1; etail = 1'b0; eirq = 1'b0;
      end else if (t && j < 2 * n + 4) begin
        esck = 1'b1; eoe = l && (j - 2 * n < 2); ebusy = 1'b0; etail = 1'b1; eirq = 1'b1;
      end else begin
        esck = 1'b1; eoe = 1'b0; ebusy = 1'b0; etail = 1'b0; eirq = 1'b1;
      end
      chk(sck, esck, poke ? "R4/R9 sck" : "R4 sck", c);
      chk(so_oe, eoe, (j < 2 * n) ? dtag : (l ? "R7 tail line" : "R6 tail line"), c);
      chk(busy, ebusy, poke ? "R9 busy" : "R5 busy", c);
      chk(tail_active, etail, t ? "R6 tail_active" : "R8 tail_active", c);
      chk(irq, eirq, "R5 irq", c);
      if (poke && c == 2) begin
        // R9 start while busy; R10 config write while busy
        start = 1'b1; cfg_we = 1'b1;
        cfg_wide = ~w; cfg_tail_en = ~t; cfg_tail_latch = ~l; cfg_div_sel = ~s;
      end else if (poke && t && c == 2 * n * h + 1) begin
        start = 1'b1;
      end else begin
        start = 1'b0; cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sck, 1'b1, "R1 sck", 0);
    chk(so_oe, 1'b0, "R1 so_oe", 0);
    chk(busy, 1'b0, "R1 busy", 0);
    chk(tail_active, 1'b0, "R1 tail_active", 0);
    chk(irq, 1'b0, "R1 irq", 0);
    for (int v = 0; v < 6; v++)
      xfer(VT[v][22], VT[v][21], VT[v][20], VT[v][19:17], VT[v][16:9], VT[v][8:1], 1'b1, VT[v][0]);
    // R10: the inverted write made during the poke vector must not have taken
    xfer(1'b0, 1'b1, 1'b1, 3'd3, 8'hEE, 8'h3B, 1'b0, 1'b0);
    // R5: irq stays set until cleared
    repeat (5) @(negedge clk);
    chk(irq, 1'b1, "R5 irq held", 0);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq, 1'b0, "R11 irq_clr", 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #600000;
    if (!done) begin
      done = 1'b1;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule